// File: doc/BRIEF.md
# Truncated Array Multiplier with Constant-Filled Operand LSBs

This block multiplies two unsigned operands with an array of AND-gate partial products that are summed by rows of full adders. Two ways of giving up accuracy for area are fixed when the block is elaborated. First, a chosen number of low bits of either operand can be overwritten with constants, all zeros or all ones, before the array sees them. Second, a chosen number of the lowest product columns can be left out of the partial-product array entirely, with no correction term added.

With no substitution and no removed columns the block is an exact multiplier. Several copies with different settings can sit side by side, so the exact, constant-filled and column-dropped results can be compared on the same operand stream. One product is captured per cycle in which the input strobe is high. The result and its valid flag appear on the next clock edge.

Top module: `trunc_array_mult`

## Requirements
- R1: With no substituted bits and TRUNC_COLS = 0, a captured product equals a_i × b_i exactly, A_W + B_W bits wide.
- R2: SUB_A_BITS low bits of a_i and SUB_B_BITS low bits of b_i are replaced by zeros when ONE_A / ONE_B is 0. The product is then the exact product of the substituted operands.
- R3: With zeros substituted on both operands, the lowest SUB_A_BITS + SUB_B_BITS product bits are always 0.
- R4: With zeros substituted on both operands, the error (exact − result) is never negative. When a_i ≥ Ea and b_i ≥ Eb, it is at most a_i·Eb + b_i·Ea − Ea·Eb, where Ea = 2^SUB_A_BITS − 1 and Eb = 2^SUB_B_BITS − 1.
- R5: When ONE_B is 1, the substituted low bits of b_i are forced to ones. The product equals the product of the substituted operands, and only the SUB_A_BITS zero bits from a_i are guaranteed to be 0 in the result.
- R6: With TRUNC_COLS = n, the result equals the sum of a_i[k]·b_i[j]·2^(k+j) over all k + j ≥ n. Product bits below n read 0.
- R7: With TRUNC_COLS = n and no substitution, the error (exact − result) lies in [0, Σ_{c<n} (c+1)·2^c].
- R8: prod_o loads only on a clock edge where in_valid_i is 1. Otherwise it holds its value, whatever a_i and b_i do.
- R9: out_valid_o is 1 in the cycle after an edge where in_valid_i is 1, and 0 after an edge where it is 0.
- R10: While rst_ni is low, out_valid_o and prod_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid; loads the product register |
| a_i | input | A_W | Multiplicand |
| b_i | input | B_W | Multiplier |
| out_valid_o | output | 1 | Product register holds a new result |
| prod_o | output | A_W+B_W | Registered product |

## Verification
The stream starts with edge operands: zero, all ones, one against all ones, a lone top bit and alternating patterns. These expose a dropped carry out of the top adder row, a partial product wired to the wrong column, or a substitution mask applied at the wrong end or with the wrong polarity. Idle cycles change the operands while the strobe is low, so a register that loads unconditionally shows a changed product. The column-dropped copy is compared bit for bit against a behavioural sum over the kept columns. A design that removed one column too many or too few would then miss by exactly that column's weight. Error bounds and forced-zero low bits are checked on each captured result, which catches a ones-filled operand that leaks constant bits into the low product bits.

// File: rtl/tam_pkg.sv
package tam_pkg;
  // count of product LSBs guaranteed zero for a given configuration
  function automatic int low_zero_bits(int sa, int sb, bit oa, bit ob, int tc);
    int z;
    z = (oa ? 0 : sa) + (ob ? 0 : sb);
    return (z > tc) ? z : tc;
  endfunction
endpackage

// File: rtl/tam_subst.sv
module tam_subst #(
  parameter int W   = 8,
  parameter int S   = 0,
  parameter bit ONE = 1'b0
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MASK = W'((64'd1 << S) - 64'd1);

  if (ONE) begin : g_one
    assign q_o = d_i | MASK;
  end else begin : g_zero
    assign q_o = d_i & ~MASK;
  end
endmodule

// File: rtl/tam_pp_array.sv
module tam_pp_array #(
  parameter int A_W        = 8,
  parameter int B_W        = 8,
  parameter int TRUNC_COLS = 0,
  localparam int P_W       = A_W + B_W
) (
  input  logic [A_W-1:0]           a_i,
  input  logic [B_W-1:0]           b_i,
  output logic [B_W-1:0][P_W-1:0]  rows_o
);
  // row j holds a & b[j] aligned at column j; dropped columns are tied low
  for (genvar j = 0; j < B_W; j++) begin : g_row
    for (genvar k = 0; k < P_W; k++) begin : g_col
      if ((k >= j) && (k - j < A_W) && (k >= TRUNC_COLS)) begin : g_and
        assign rows_o[j][k] = a_i[k-j] & b_i[j];
      end else begin : g_tie
        assign rows_o[j][k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tam_fa.sv
module tam_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic hs;
  assign hs  = x_i ^ y_i;
  assign s_o = hs ^ c_i;
  assign c_o = (x_i & y_i) | (hs & c_i);
endmodule

// File: rtl/tam_row_add.sv
module tam_row_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] c;
  assign c[0] = 1'b0;

  // result never exceeds W bits, so the top cell needs no carry out
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_fa
      tam_fa u_fa (
        .x_i(x_i[i]), .y_i(y_i[i]), .c_i(c[i]),
        .s_o(s_o[i]), .c_o(c[i+1])
      );
    end else begin : g_top
      assign s_o[i] = x_i[i] ^ y_i[i] ^ c[i];
    end
  end
endmodule

// File: rtl/trunc_array_mult.sv
module trunc_array_mult #(
  parameter int A_W        = 8,
  parameter int B_W        = 8,
  parameter int SUB_A_BITS = 0,
  parameter int SUB_B_BITS = 0,
  parameter bit ONE_A      = 1'b0,
  parameter bit ONE_B      = 1'b0,
  parameter int TRUNC_COLS = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic               out_valid_o,
  output logic [A_W+B_W-1:0] prod_o
);
  localparam int P_W      = A_W + B_W;
  localparam int LOW_ZERO = tam_pkg::low_zero_bits(SUB_A_BITS, SUB_B_BITS, ONE_A, ONE_B, TRUNC_COLS);
  localparam bit NO_ONES  = !(ONE_A && SUB_A_BITS > 0) && !(ONE_B && SUB_B_BITS > 0);

  logic [A_W-1:0]          a_eff;
  logic [B_W-1:0]          b_eff;
  logic [B_W-1:0][P_W-1:0] rows;
  logic [P_W-1:0]          acc [B_W];
  logic [P_W-1:0]          prod_q;
  logic                    valid_q;

  tam_subst #(.W(A_W), .S(SUB_A_BITS), .ONE(ONE_A)) u_sub_a (.d_i(a_i), .q_o(a_eff));
  tam_subst #(.W(B_W), .S(SUB_B_BITS), .ONE(ONE_B)) u_sub_b (.d_i(b_i), .q_o(b_eff));

  tam_pp_array #(.A_W(A_W), .B_W(B_W), .TRUNC_COLS(TRUNC_COLS)) u_pp (
    .a_i(a_eff), .b_i(b_eff), .rows_o(rows)
  );

  assign acc[0] = rows[0];
  for (genvar j = 1; j < B_W; j++) begin : g_sum
    tam_row_add #(.W(P_W)) u_add (.x_i(acc[j-1]), .y_i(rows[j]), .s_o(acc[j]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) prod_q <= acc[B_W-1];
    end
  end

  assign prod_o      = prod_q;
  assign out_valid_o = valid_q;
endmodule

// File: rtl/tam_chk.sv
module tam_chk #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter int LOW_ZERO = 0,
  parameter bit NO_ONES  = 1'b1,
  localparam int P_W     = A_W + B_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic [A_W-1:0] a_i,
  input logic [B_W-1:0] b_i,
  input logic           out_valid_o,
  input logic [P_W-1:0] prod_o
);
  localparam logic [P_W-1:0] LSB_MASK = P_W'((64'd1 << LOW_ZERO) - 64'd1);

  logic [P_W-1:0] exact;
  assign exact = P_W'(a_i) * P_W'(b_i);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(prod_o)); // R8
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((prod_o & LSB_MASK) == '0)); // R3

  if (NO_ONES) begin : g_under
    AST_NO_OVERSHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (prod_o <= $past(exact))); // R7
  end
endmodule

bind trunc_array_mult tam_chk #(
  .A_W(A_W), .B_W(B_W), .LOW_ZERO(LOW_ZERO), .NO_ONES(NO_ONES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .prod_o(prod_o)
);

// File: tb/trunc_array_mult_test.sv
module trunc_array_mult_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni;
  logic       in_valid;
  logic [7:0] a, b;
  logic       v0, v1, v2, v3;
  logic [15:0] p0, p1, p2, p3;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  trunc_array_mult uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a), .b_i(b),
    .out_valid_o(v0), .prod_o(p0));
  trunc_array_mult #(.SUB_A_BITS(2), .SUB_B_BITS(3)) uut_zs (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a), .b_i(b),
    .out_valid_o(v1), .prod_o(p1));
  trunc_array_mult #(.SUB_A_BITS(2), .SUB_B_BITS(2), .ONE_B(1'b1)) uut_mix (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a), .b_i(b),
    .out_valid_o(v2), .prod_o(p2));
  trunc_array_mult #(.TRUNC_COLS(5)) uut_tr (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a), .b_i(b),
    .out_valid_o(v3), .prod_o(p3));

  // reference model: last captured operands and valid flag
  logic       ev, loaded;
  logic [7:0] la, lb;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ev <= 1'b0; loaded <= 1'b0; la <= '0; lb <= '0;
    end else begin
      ev <= in_valid;
      if (in_valid) begin
        la <= a; lb <= b; loaded <= 1'b1;
      end
    end
  end

  function automatic longint sub_op(longint x, int s, bit one);
    longint m = (longint'(1) << s) - 1;
    return one ? (x | m) : (x & ~m);
  endfunction

  function automatic longint kept_cols(longint x, longint y, int n);
    longint s = 0;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++)
        if (k + j >= n) s += ((x >> k) & 1) * ((y >> j) & 1) * (longint'(1) << (k + j));
    return s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic compare_all();
    longint ex, e0, e1, e2, e3, err;
    string  tag;
    ex = longint'(la) * longint'(lb);
    e0 = loaded ? ex : 0;
    e1 = loaded ? sub_op(la, 2, 0) * sub_op(lb, 3, 0) : 0;
    e2 = loaded ? sub_op(la, 2, 0) * sub_op(lb, 2, 1) : 0;
    e3 = loaded ? kept_cols(la, lb, 5) : 0;
    chk(v0 == ev, "R9 uut valid", v0, ev);
    chk(v1 == ev, "R9 uut_zs valid", v1, ev);
    chk(v2 == ev, "R9 uut_mix valid", v2, ev);
    chk(v3 == ev, "R9 uut_tr valid", v3, ev);
    tag = ev ? "R1" : "R8";
    chk(p0 == e0, {tag, " exact"}, p0, e0);
    tag = ev ? "R2" : "R8";
    chk(p1 == e1, {tag, " zero-sub"}, p1, e1);
    tag = ev ? "R5" : "R8";
    chk(p2 == e2, {tag, " one-sub"}, p2, e2);
    tag = ev ? "R6" : "R8";
    chk(p3 == e3, {tag, " trunc"}, p3, e3);
    if (ev) begin
      chk(p1[4:0] == 5'd0, "R3 zero-sub low bits", p1[4:0], 0);
      chk(p2[1:0] == 2'd0, "R5 one-sub low bits", p2[1:0], 0);
      err = ex - longint'(p1);
      chk(err >= 0, "R4 zero-sub error sign", err, 0);
      if (la >= 3 && lb >= 7)
        chk(err <= la * 7 + lb * 3 - 21, "R4 zero-sub error bound", err, la * 7 + lb * 3 - 21);
      err = ex - longint'(p3);
      chk(err >= 0 && err <= 129, "R7 trunc error range", err, 129);
    end
  endtask

  task automatic step(bit iv, logic [7:0] xa, logic [7:0] xb);
    @(negedge clk);
    compare_all();
    in_valid = iv; a = xa; b = xb;
  endtask

  initial begin
    logic [31:0] lf;
    logic [7:0] da [9] = '{8'd0, 8'd255, 8'd1, 8'd255, 8'd128, 8'd170, 8'd3, 8'd4, 8'd255};
    logic [7:0] db [9] = '{8'd0, 8'd255, 8'd255, 8'd1, 8'd128, 8'd85, 8'd7, 8'd8, 8'd0};
    rst_ni = 1'b0; in_valid = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    chk({v0, v1, v2, v3} == 4'b0, "R10 reset valid", {v0, v1, v2, v3}, 0);
    chk((p0 | p1 | p2 | p3) == 16'd0, "R10 reset product", p0 | p1 | p2 | p3, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 9; i++) begin
      step(1'b1, da[i], db[i]);
      step(1'b0, ~da[i], 8'h5a ^ db[i]);  // R8: operands move while idle
    end
    lf = 32'h1d2c3b4a;
    for (int i = 0; i < 400; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      step(lf[0] | lf[1], lf[15:8], lf[23:16]);
    end
    step(1'b0, 8'd0, 8'd0);
    step(1'b0, 8'd0, 8'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule